// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight interrupt request lines for a small processor core. Requests are captured into a pending register, but only on instruction-cycle strobes that the core marks as non-I/O. When a pending level outranks every level already in service and the global enable flag is set, the block raises a one-clock acknowledge. Along with it the block gives the winning level, a call vector and a request to push the program counter. It then marks that level as active and clears the enable flag.

Software can set the enable flag again inside a handler, so that a higher level can nest on top of the running one. A return pulse from the core retires the highest active level. The return clears that level's active and pending bits and sets the enable flag again. A level's pending bit lives until its handler returns. A repeat request that arrives during service is therefore merged into the bit already set. The return stack, program counter saving and bank register saving are handled by the core.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the pending register, the active register, the enable flag, `ack_o`, `push_pc_o`, `ack_lvl_o` and `ack_vec_o`.
- R2: At a clock edge with `cyc_i`=1 and `io_cyc_i`=0, every set bit of `req_i` is ORed into the pending register. At any other edge no pending bit is newly set. Bit i of `pend_o` and of `req_i` belongs to level i.
- R3: A request for a level whose pending bit is already set has no effect. The request is merged and only one acknowledge results.
- R4: An acknowledge is taken at a clock edge where `cyc_i`=1, the enable flag is set, and the highest pending level is above the highest active level (or no level is active). In the next clock `ack_o` and `push_pc_o` are both 1 for exactly one clock, and the level's bit in `act_o` is set.
- R5: Level 7 has the highest priority and level 0 the lowest. The acknowledged level, given on `ack_lvl_o`, is the highest set pending bit.
- R6: A pending level that is at or below the highest active level is not acknowledged. A higher one is acknowledged and nests above it.
- R7: With each acknowledge, `ack_vec_o` equals VEC_BASE + level × VEC_STRIDE. The defaults are 0x040 and 4.
- R8: While the enable flag is clear, requests are still recorded as pending. No acknowledge occurs until the flag is set again.
- R9: A clock edge with `rti_i`=1 while some active bit is set clears the highest active bit and the pending bit of the same level, and sets the enable flag. With no active bit set, `rti_i` changes nothing.
- R10: `ie_set_i` sets the enable flag and `ie_clr_i` clears it. When both are high, clear wins. A return sets the flag over either control. Taking an acknowledge clears the flag over every other source.
- R11: A request that is sampled on the same edge as the return of its own level is kept as pending.
- R12: A request that is sampled on one strobe is acknowledged on the next `cyc_i` strobe, if it is enabled and of high enough priority. I/O cycles and gaps between strobes add to this latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_LVL | Request lines, one per level |
| cyc_i | input | 1 | Instruction-cycle strobe |
| io_cyc_i | input | 1 | Marks the current cycle as an I/O cycle |
| rti_i | input | 1 | Return-from-interrupt pulse |
| ie_set_i | input | 1 | Sets the enable flag |
| ie_clr_i | input | 1 | Clears the enable flag |
| ack_o | output | 1 | One-clock acknowledge pulse |
| push_pc_o | output | 1 | Request to push the program counter |
| ack_lvl_o | output | $clog2(NUM_LVL) | Acknowledged level |
| ack_vec_o | output | VEC_W | Call vector for the acknowledged level |
| ie_o | output | 1 | Enable flag |
| pend_o | output | NUM_LVL | Pending register |
| act_o | output | NUM_LVL | Active register |

## Verification
Directed sequences cover several cases: a request held back while the flag is clear, a repeat request merged during service, and a lower or equal level blocked beneath an active one. They also cover a high level nesting above it, a request offered in an I/O cycle, and a return that coincides with a new request for the same level. Together these separate the sampling gate from the enable gate, and the pending lifetime from the active lifetime. Several thousand random cycles then mix sparse multi-bit requests, strobe gaps, I/O cycles, returns and both enable controls. A cycle-accurate model in the bench tracks them, which catches wrong priority order and wrong precedence among the enable-flag sources.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Call vector for a level: base plus a fixed stride per level.
  function automatic int unsigned lvl_vector(input int unsigned base,
                                             input int unsigned stride,
                                             input int unsigned lvl);
    return base + lvl * stride;
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);

  // Highest set bit wins: scanning upward, later hits overwrite earlier ones.
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_ack_arb.sv
module irq_ack_arb #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  act_i,
  input  logic          ie_i,
  input  logic          cyc_i,
  input  logic          rti_i,
  output logic          take_o,
  output logic [IW-1:0] win_o,
  output logic          ret_o,
  output logic [IW-1:0] ret_lvl_o
);

  logic          p_vld;
  logic [IW-1:0] p_idx;
  logic          a_vld;
  logic [IW-1:0] a_idx;

  irq_prio_enc #(.N(N), .IW(IW)) u_pend_enc (
    .vec_i (pend_i),
    .vld_o (p_vld),
    .idx_o (p_idx)
  );

  irq_prio_enc #(.N(N), .IW(IW)) u_act_enc (
    .vec_i (act_i),
    .vld_o (a_vld),
    .idx_o (a_idx)
  );

  // A pending level must strictly outrank the level in service.
  assign take_o    = cyc_i && ie_i && p_vld && (!a_vld || (p_idx > a_idx));
  assign win_o     = p_idx;
  // A return only retires something when a level is in service.
  assign ret_o     = rti_i && a_vld;
  assign ret_lvl_o = a_idx;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NUM_LVL    = 8,
  parameter int VEC_W      = 12,
  parameter int VEC_BASE   = 'h040,
  parameter int VEC_STRIDE = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LVL-1:0]         req_i,
  input  logic                       cyc_i,
  input  logic                       io_cyc_i,
  input  logic                       rti_i,
  input  logic                       ie_set_i,
  input  logic                       ie_clr_i,
  output logic                       ack_o,
  output logic                       push_pc_o,
  output logic [$clog2(NUM_LVL)-1:0] ack_lvl_o,
  output logic [VEC_W-1:0]           ack_vec_o,
  output logic                       ie_o,
  output logic [NUM_LVL-1:0]         pend_o,
  output logic [NUM_LVL-1:0]         act_o
);

  import irq_nest_pkg::*;

  localparam int LVL_W = $clog2(NUM_LVL);

  logic [NUM_LVL-1:0] pend_q, pend_n;
  logic [NUM_LVL-1:0] act_q, act_n;
  logic               ie_q, ie_n;
  logic               ack_q, push_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [VEC_W-1:0]   vec_q, vec_n;

  logic               take, ret, smp;
  logic [LVL_W-1:0]   win, ret_lvl;

  irq_ack_arb #(.N(NUM_LVL), .IW(LVL_W)) u_arb (
    .pend_i    (pend_q),
    .act_i     (act_q),
    .ie_i      (ie_q),
    .cyc_i     (cyc_i),
    .rti_i     (rti_i),
    .take_o    (take),
    .win_o     (win),
    .ret_o     (ret),
    .ret_lvl_o (ret_lvl)
  );

  // Requests are captured only on non-I/O instruction strobes.
  assign smp = cyc_i && !io_cyc_i;

  // Per-level next state: a return clears first, a fresh sample re-sets,
  // so a request coinciding with its own level's return survives.
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic hit_ret, hit_take;
    assign hit_ret   = ret  && (ret_lvl == LVL_W'(g));
    assign hit_take  = take && (win     == LVL_W'(g));
    assign pend_n[g] = (pend_q[g] && !hit_ret) || (smp && req_i[g]);
    assign act_n[g]  = (act_q[g]  && !hit_ret) || hit_take;
  end

  // Enable flag precedence, lowest to highest: set, clear, return, acknowledge.
  always_comb begin
    ie_n = ie_q;
    if (ie_set_i) ie_n = 1'b1;
    if (ie_clr_i) ie_n = 1'b0;
    if (ret)      ie_n = 1'b1;
    if (take)     ie_n = 1'b0;
  end

  assign vec_n = VEC_W'(lvl_vector(VEC_BASE, VEC_STRIDE, int'(win)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
      ie_q   <= 1'b0;
      ack_q  <= 1'b0;
      push_q <= 1'b0;
      lvl_q  <= '0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
      ie_q   <= ie_n;
      ack_q  <= take;
      push_q <= take;
      if (take) begin
        lvl_q <= win;
        vec_q <= vec_n;
      end
    end
  end

  assign ack_o     = ack_q;
  assign push_pc_o = push_q;
  assign ack_lvl_o = lvl_q;
  assign ack_vec_o = vec_q;
  assign ie_o      = ie_q;
  assign pend_o    = pend_q;
  assign act_o     = act_q;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NUM_LVL    = 8,
  parameter int VEC_W      = 12,
  parameter int VEC_BASE   = 'h040,
  parameter int VEC_STRIDE = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cyc_i,
  input logic                       io_cyc_i,
  input logic                       rti_i,
  input logic                       ack_o,
  input logic                       push_pc_o,
  input logic [$clog2(NUM_LVL)-1:0] ack_lvl_o,
  input logic [VEC_W-1:0]           ack_vec_o,
  input logic                       ie_o,
  input logic [NUM_LVL-1:0]         pend_o,
  input logic [NUM_LVL-1:0]         act_o
);

  AST_ACK_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o); // R4

  AST_PUSH_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    push_pc_o == ack_o); // R4

  AST_ACK_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(ie_o)); // R8

  AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !ie_o); // R10

  AST_ACK_LVL_LIVE: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (act_o[ack_lvl_o] && pend_o[ack_lvl_o])); // R6

  AST_ACK_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> ((act_o >> ack_lvl_o) == NUM_LVL'(1))); // R5

  AST_NO_IO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !(cyc_i && !io_cyc_i) |=> ((pend_o & ~$past(pend_o)) == '0)); // R2

  AST_RET_SETS_IE: assert property (@(posedge clk) disable iff (rst)
    (rti_i && (act_o != '0)) |=> (ie_o || ack_o)); // R9

  AST_VEC_OF_LVL: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (ack_vec_o == VEC_W'(VEC_BASE + int'(ack_lvl_o) * VEC_STRIDE))); // R7

endmodule

bind irq_nest_ctrl irq_nest_chk #(
  .NUM_LVL    (NUM_LVL),
  .VEC_W      (VEC_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_i     (cyc_i),
  .io_cyc_i  (io_cyc_i),
  .rti_i     (rti_i),
  .ack_o     (ack_o),
  .push_pc_o (push_pc_o),
  .ack_lvl_o (ack_lvl_o),
  .ack_vec_o (ack_vec_o),
  .ie_o      (ie_o),
  .pend_o    (pend_o),
  .act_o     (act_o)
);

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;

  localparam int N  = 8;
  localparam int LW = 3;
  localparam int VW = 12;
  localparam int VB = 'h040;
  localparam int VS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_i = '0;
  logic          cyc_i = 1'b0, io_cyc_i = 1'b0, rti_i = 1'b0;
  logic          ie_set_i = 1'b0, ie_clr_i = 1'b0;
  logic          ack_o, push_pc_o, ie_o;
  logic [LW-1:0] ack_lvl_o;
  logic [VW-1:0] ack_vec_o;
  logic [N-1:0]  pend_o, act_o;

  always #2 clk = ~clk;

  irq_nest_ctrl #(.NUM_LVL(N), .VEC_W(VW), .VEC_BASE(VB), .VEC_STRIDE(VS)) i_irq_nest_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .cyc_i(cyc_i), .io_cyc_i(io_cyc_i),
    .rti_i(rti_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .ack_o(ack_o),
    .push_pc_o(push_pc_o), .ack_lvl_o(ack_lvl_o), .ack_vec_o(ack_vec_o),
    .ie_o(ie_o), .pend_o(pend_o), .act_o(act_o)
  );

  int vecs = 0;
  int errs = 0;

  logic [N-1:0]  m_pend = '0, m_act = '0;
  logic          m_ie = 1'b0, m_ack = 1'b0;
  logic [LW-1:0] m_lvl = '0;

  function automatic int hi(input logic [N-1:0] v);
    int r = -1;
    for (int i = 0; i < N; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 pending", 32'(pend_o), 32'(m_pend));
    chk("R6 active", 32'(act_o), 32'(m_act));
    chk("R10 enable", 32'(ie_o), 32'(m_ie));
    chk("R4 ack", 32'(ack_o), 32'(m_ack));
    chk("R4 push", 32'(push_pc_o), 32'(m_ack));
    if (m_ack) begin
      chk("R5 level", 32'(ack_lvl_o), 32'(m_lvl));
      chk("R7 vector", 32'(ack_vec_o), 32'(VW'(VB + int'(m_lvl) * VS)));
    end
  endtask

  // Drive one clock of stimulus, advance the model, compare after the edge.
  task automatic step(input logic [N-1:0] rq, input logic cy, input logic io,
                      input logic rt, input logic st, input logic cl);
    int hp, ha;
    logic take, rv, ni;
    logic [N-1:0] np, na;
    req_i = rq; cyc_i = cy; io_cyc_i = io; rti_i = rt; ie_set_i = st; ie_clr_i = cl;
    hp = hi(m_pend);
    ha = hi(m_act);
    take = cy && m_ie && (hp >= 0) && (hp > ha);
    rv = rt && (ha >= 0);
    np = m_pend;
    na = m_act;
    if (rv) begin np[ha] = 1'b0; na[ha] = 1'b0; end
    if (take) na[hp] = 1'b1;
    if (cy && !io) np = np | rq;
    ni = m_ie;
    if (st) ni = 1'b1;
    if (cl) ni = 1'b0;
    if (rv) ni = 1'b1;
    if (take) ni = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_pend = np; m_act = na; m_ie = ni; m_ack = take;
    if (take) m_lvl = LW'(hp);
    compare_all();
  endtask

  task automatic check_reset();
    chk("R1 pending", 32'(pend_o), 0);
    chk("R1 active", 32'(act_o), 0);
    chk("R1 enable", 32'(ie_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
    chk("R1 push", 32'(push_pc_o), 0);
    chk("R1 level", 32'(ack_lvl_o), 0);
    chk("R1 vector", 32'(ack_vec_o), 0);
    m_pend = '0; m_act = '0; m_ie = 1'b0; m_ack = 1'b0; m_lvl = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2417);
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;

    // R8: recorded while disabled, served only after enable.
    step(8'h04, 1, 0, 0, 0, 0);
    step(8'h00, 1, 0, 0, 0, 0);
    chk("R8 no ack while disabled", 32'(ack_o), 0);
    step(8'h00, 0, 0, 0, 1, 0);
    step(8'h00, 1, 0, 0, 0, 0);
    chk("R8 ack after enable", 32'(ack_o), 1);
    // R3: repeat request during service merges.
    step(8'h04, 1, 0, 0, 0, 0);
    chk("R3 merged request", 32'(pend_o), 32'h04);
    step(8'h00, 0, 0, 0, 1, 0);
    // R6: lower and equal levels blocked under level 2.
    step(8'h01, 1, 0, 0, 0, 0);
    step(8'h00, 1, 0, 0, 0, 0);
    chk("R6 lower blocked", 32'(ack_o), 0);
    // R2: I/O cycle does not sample.
    step(8'h80, 1, 1, 0, 0, 0);
    chk("R2 io not sampled", 32'(pend_o), 32'h05);
    step(8'h80, 1, 0, 0, 0, 0);
    // R12: acknowledged on the very next strobe.
    step(8'h00, 1, 0, 0, 0, 0);
    chk("R12 next strobe ack", 32'(ack_o), 1);
    chk("R6 nested level", 32'(ack_lvl_o), 7);
    // R9: return retires level 7.
    step(8'h00, 0, 0, 1, 0, 0);
    chk("R9 retire top", 32'(act_o), 32'h04);
    step(8'h00, 0, 0, 0, 0, 0);
    // R11: request on the return edge of its own level survives.
    step(8'h04, 1, 0, 1, 0, 0);
    chk("R11 kept on return", 32'(pend_o), 32'h05);
    step(8'h00, 1, 0, 0, 0, 0);
    step(8'h00, 0, 0, 1, 0, 0);
    step(8'h00, 1, 0, 0, 0, 0);
    chk("R7 level 0 vector", 32'(ack_vec_o), 32'h040);
    step(8'h00, 0, 0, 1, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1);
    step(8'h00, 0, 0, 1, 0, 0);
    chk("R9 empty return ignored", 32'(ie_o), 0);
    step(8'h00, 0, 0, 0, 1, 1);
    chk("R10 clear beats set", 32'(ie_o), 0);

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rq;
      rq = (($urandom % 5) == 0) ? (N'($urandom) & N'($urandom)) : '0;
      step(rq, ($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 7) == 0,
           ($urandom % 4) == 0, ($urandom % 11) == 0);
    end

    // R1: reset in the middle of activity.
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    step(8'h00, 1, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule